// File: doc/BRIEF.md
# Bus Width Sizing Adapter

This block connects a 32-bit internal request port to an external data bus that is either 32 or 16 bits wide. The width is fixed by a strap input that is captured only while reset is held. A request (address, access size, direction, write data) is accepted while the block is idle. It is then run as a sequence of bus states. The result is returned as a one-cycle completion pulse that carries a 32-bit read word.

In wide mode every access has an address state followed by one data state, and all four byte lanes pass straight through. In narrow mode only data lanes 15:0 are used. A byte or halfword access is steered onto those lanes from whichever half of the word it addresses. A word access becomes two halfword beats, low half first. The four byte-enable outputs are redefined in narrow mode as two lane enables, a halfword flag and address bit 1. Every data state waits for the external ready input.

Top module: `bus_sizer`

## Requirements
- R1: After reset the block is idle (`bus_phase`=0), drives no byte enables or data, has `rsp_done` low and `rsp_rdata` zero, and has `req_ready` high.
- R2: `strap_narrow` is captured on every clock edge while `rst_n` is low, and later changes to it have no effect on how accesses run.
- R3: In wide mode every access is address state then one data state (`bus_phase` 1 then 2). `bus_be` is one-hot at bit addr[1:0] for a byte, 4'b0011 or 4'b1100 by addr[1] for a halfword, and 4'b1111 for a word. A write drives `req_wdata` on all 32 lanes (`bus_doe`=2'b11), and a read returns all 32 lanes of `bus_din`.
- R4: In narrow mode `bus_doe[1]` is never set, and the value on `bus_din[31:16]` never reaches `rsp_rdata`.
- R5: In narrow mode a byte or halfword access is address state then one data state. `bus_be[0]` enables lane 7:0 and `bus_be[1]` enables lane 15:8: both are set for a halfword, and only the one picked by addr[0] for a byte. `bus_be[2]` is set for halfword and word beats only, and `bus_be[3]` equals addr[1].
- R6: In narrow mode a word access runs address, first word state, second word state (`bus_phase` 1, 3, 4), with `bus_be[2:0]`=3'b111. `bus_be[3]` is 0 in the first two states and 1 in the last.
- R7: A narrow word read takes bits 15:0 of the result from lanes 15:0 at the end of the first word state and bits 31:16 at the end of the second.
- R8: A narrow word write drives `req_wdata[15:0]` on lanes 15:0 in the address and first word states and `req_wdata[31:16]` in the second word state.
- R9: A narrow byte or halfword access with addr[1]=1 drives `req_wdata[31:16]` on lanes 15:0 when writing, and places lanes 15:0 in `rsp_rdata[31:16]` when reading. With addr[1]=0 it uses bits 15:0 on both sides. The half that is not addressed reads as zero.
- R10: The address state always lasts one cycle, and each data state repeats until `bus_ready` is sampled high.
- R11: `rsp_done` is a one-cycle pulse in the cycle after the final ready edge, with `rsp_rdata` valid in that cycle. `req_ready` is high only when idle, and `bus_start` is high only in the address state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_narrow | input | 1 | Width strap, 1 selects the 16-bit bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write word in internal lane order |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 32 | Packed read word |
| bus_addr | output | ADDR_W-2 | Word address |
| bus_be | output | 4 | Byte enables (narrow: lane0, lane1, halfword, A1) |
| bus_start | output | 1 | High in the address state |
| bus_write | output | 1 | Access in progress is a write |
| bus_phase | output | 3 | 0 idle, 1 address, 2 data, 3 first word, 4 second word |
| bus_dout | output | 32 | Outgoing lane data |
| bus_doe | output | 2 | Drive enable for lanes 15:0 and 31:16 |
| bus_din | input | 32 | Incoming lane data |
| bus_ready | input | 1 | Ends the current data state |

## Verification
A request presented before a clock edge shows on `bus_phase`=1 right after that edge. Each data state ends at the first edge where `bus_ready` is high. The completion pulse and the packed word appear one edge after the final ready. The bench drives inputs and samples outputs at the falling edge. It keeps its own count of states and of wait cycles. From that count it works out both the state order and the total number of busy cycles, and it checks the byte enables and lane data in every cycle between those edges.

// File: rtl/bus_sizer_pkg.sv
// Shared constants and encodings for the bus width sizing adapter.
// Assumes a 32-bit internal word split into two 16-bit halves.
package bus_sizer_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int BE_W   = DATA_W / 8;

    // Access size codes on the request port (code 3 behaves as a word).
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Bus state encoding, visible on the phase output.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TA   = 3'd1,
        PH_TS   = 3'd2,
        PH_TW1  = 3'd3,
        PH_TW2  = 3'd4
    } phase_e;
endpackage

// File: rtl/bus_sizer_seq.sv
// Bus state sequencer: captures the width strap during reset, latches a
// request when idle and steps through address and data states.
// Assumes the requester holds nothing after acceptance (fields are latched).
module bus_sizer_seq
    import bus_sizer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_narrow,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_ready,
    output phase_e            phase,
    output logic              mode16,
    output logic              accept,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [1:0]        lat_size,
    output logic              lat_write,
    output logic [DATA_W-1:0] lat_wdata
);

    // Acceptance only in idle.
    always_comb accept = (phase == PH_IDLE) && req_valid;

    // Strap capture during reset, request latch and state stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            mode16    <= strap_narrow;
            lat_addr  <= '0;
            lat_size  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase     <= PH_TA;
                        lat_addr  <= req_addr;
                        lat_size  <= req_size;
                        lat_write <= req_write;
                        lat_wdata <= req_wdata;
                    end
                end
                PH_TA:   phase <= (mode16 && lat_size[1]) ? PH_TW1 : PH_TS;
                PH_TS:   if (bus_ready) phase <= PH_IDLE;
                PH_TW1:  if (bus_ready) phase <= PH_TW2;
                PH_TW2:  if (bus_ready) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Width mode frozen once out of reset.
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode16));

    // Address state lasts one cycle and leads to a data state.
    p_ta_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TA) |=> (phase != PH_TA) && (phase != PH_IDLE));

    // Data states hold while ready is low.
    p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) && (phase != PH_TA) && !bus_ready |=> $stable(phase));

    // Narrow word goes to the first word state.
    p_word_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TA) && mode16 && lat_size[1] |=> (phase == PH_TW1));

    // First word state is followed by the second.
    p_word_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TW1) && bus_ready |=> (phase == PH_TW2));

endmodule

// File: rtl/bus_sizer_lanes.sv
// Lane steering: derives byte enables, outgoing lane data, drive enables
// and the start strobe from the current state and the latched request.
// Assumes aligned halfword and word addresses.
module bus_sizer_lanes
    import bus_sizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              mode16,
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        doe,
    output logic              start
);

    logic hi_beat;

    // Enables and data for the active state, all quiet when idle.
    always_comb begin
        be      = '0;
        dout    = '0;
        doe     = '0;
        start   = 1'b0;
        hi_beat = 1'b0;
        if (phase != PH_IDLE) begin
            start = (phase == PH_TA);
            if (mode16) begin
                hi_beat = size[1] ? (phase == PH_TW2) : addr_lo[1];
                if (size != SZ_BYTE) begin
                    be[2:0] = 3'b111;
                end else begin
                    be[0] = !addr_lo[0];
                    be[1] = addr_lo[0];
                end
                be[3]          = hi_beat;
                dout[HALF_W-1:0] = hi_beat ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];
                doe            = {1'b0, write};
            end else begin
                if (size[1])
                    be = 4'b1111;
                else if (size == SZ_HALF)
                    be = addr_lo[1] ? 4'b1100 : 4'b0011;
                else
                    be = 4'b0001 << addr_lo;
                dout = wdata;
                doe  = {write, write};
            end
        end
    end

    // A1 low during the first beat of a narrow word.
    p_a1_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode16 && (phase == PH_TW1) |-> !be[3]);

    // A1 high during the second beat of a narrow word.
    p_a1_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode16 && (phase == PH_TW2) |-> be[3]);

    // Narrow byte access uses exactly one lane and no halfword flag.
    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode16 && (phase != PH_IDLE) && (size == SZ_BYTE) |-> $onehot(be[1:0]) && !be[2]);

endmodule

// File: rtl/bus_sizer_rdpack.sv
// Read packing: collects incoming lanes into a 32-bit read word and
// raises the completion pulse after the final ready edge.
// Assumes the buffer is cleared at each acceptance.
module bus_sizer_rdpack
    import bus_sizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  phase_e            phase,
    input  logic              mode16,
    input  logic              addr1,
    input  logic              write,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    // Fill the read word from the sampled lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (accept) begin
            rdata <= '0;
        end else if (!write && bus_ready) begin
            case (phase)
                PH_TS: begin
                    if (!mode16)
                        rdata <= bus_din;
                    else if (addr1)
                        rdata[DATA_W-1:HALF_W] <= bus_din[HALF_W-1:0];
                    else
                        rdata[HALF_W-1:0] <= bus_din[HALF_W-1:0];
                end
                PH_TW1:  rdata[HALF_W-1:0]      <= bus_din[HALF_W-1:0];
                PH_TW2:  rdata[DATA_W-1:HALF_W] <= bus_din[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    // Completion pulse after the last data state ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= bus_ready && ((phase == PH_TS) || (phase == PH_TW2));
    end

    // Completion never lasts two cycles.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/bus_sizer.sv
// Bus width sizing adapter top: joins the sequencer, lane steering and
// read packing. Assumes the width strap is stable near the end of reset.
module bus_sizer
    import bus_sizer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_narrow,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    output logic [ADDR_W-3:0] bus_addr,
    output logic [3:0]        bus_be,
    output logic              bus_start,
    output logic              bus_write,
    output logic [2:0]        bus_phase,
    output logic [31:0]       bus_dout,
    output logic [1:0]        bus_doe,
    input  logic [31:0]       bus_din,
    input  logic              bus_ready
);

    phase_e            phase;
    logic              mode16;
    logic              accept;
    logic [ADDR_W-1:0] lat_addr;
    logic [1:0]        lat_size;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;

    bus_sizer_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_narrow (strap_narrow),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .bus_ready    (bus_ready),
        .phase        (phase),
        .mode16       (mode16),
        .accept       (accept),
        .lat_addr     (lat_addr),
        .lat_size     (lat_size),
        .lat_write    (lat_write),
        .lat_wdata    (lat_wdata)
    );

    bus_sizer_lanes u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .mode16  (mode16),
        .addr_lo (lat_addr[1:0]),
        .size    (lat_size),
        .write   (lat_write),
        .wdata   (lat_wdata),
        .be      (bus_be),
        .dout    (bus_dout),
        .doe     (bus_doe),
        .start   (bus_start)
    );

    bus_sizer_rdpack u_rdpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .phase     (phase),
        .mode16    (mode16),
        .addr1     (lat_addr[1]),
        .write     (lat_write),
        .bus_ready (bus_ready),
        .bus_din   (bus_din),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    // Port-level views of the state.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        bus_phase = phase;
        bus_addr  = lat_addr[ADDR_W-1:2];
        bus_write = lat_write && (phase != PH_IDLE);
    end

    // Nothing is enabled or driven while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 3'd0) |-> (bus_be == 4'd0) && (bus_doe == 2'd0));

    // Completion only while idle and only after a ready edge.
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_phase == 3'd0) && $past(bus_ready));

endmodule

// File: tb/bus_sizer_bench.sv
// Directed bench for the bus width sizing adapter.
module bus_sizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_narrow = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_start;
    logic        bus_write;
    logic [2:0]  bus_phase;
    logic [31:0] bus_dout;
    logic [1:0]  bus_doe;
    logic [31:0] bus_din = '0;
    logic        bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    logic narrow = 1'b0;

    always #2 clk = ~clk;

    bus_sizer u_bus_sizer (
        .clk(clk), .rst_n(rst_n), .strap_narrow(strap_narrow),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_start(bus_start), .bus_write(bus_write),
        .bus_phase(bus_phase), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ready(bus_ready)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(logic nar, logic [2:0] ph, logic [1:0] sz, logic [1:0] a);
        logic hi;
        if (nar) begin
            hi = sz[1] ? (ph == 3'd4) : a[1];
            return {hi, (sz != 2'd0) ? 3'b111 : {1'b0, a[0], !a[0]}};
        end
        if (sz[1]) return 4'b1111;
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b0001 << a;
    endfunction

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_narrow = strap;
        narrow = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access with per-cycle checks; returns state code and read word.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] ad,
                          input logic [31:0] wd, input logic [31:0] rd, input int waits,
                          output int seq, output logic [31:0] rword);
        logic [2:0] ph;
        logic [2:0] last = 3'd0;
        int k = 0;
        int cyc = 0;
        logic seen = 1'b0;
        logic word16;
        logic [31:0] exp_rd;
        seq = 0;
        rword = '0;
        word16 = narrow && sz[1];
        @(negedge clk);
        check("R11 ready when idle", req_ready, 1'b1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 64; n++) begin
            ph = bus_phase;
            if (rsp_done) begin
                seen = 1'b1;
                rword = rsp_rdata;
                check("R11 done while idle", ph, 3'd0);
                break;
            end
            if (ph != last) begin
                seq = seq * 8 + int'(ph);
                k = 0;
                last = ph;
            end
            check(narrow ? "R5 R6 byte enables" : "R3 byte enables", bus_be, exp_be(narrow, ph, sz, ad[1:0]));
            check("R11 start strobe", bus_start, ph == 3'd1);
            check("R11 ready busy", req_ready, 1'b0);
            check(narrow ? "R4 drive enables" : "R3 drive enables", bus_doe,
                  wr ? (narrow ? 2'b01 : 2'b11) : 2'b00);
            if (wr) begin
                if (!narrow)
                    check("R3 write lanes", bus_dout, wd);
                else if (sz[1])
                    check("R8 word write lanes", bus_dout[15:0], (ph == 3'd4) ? wd[31:16] : wd[15:0]);
                else
                    check("R9 halfword write steering", bus_dout[15:0], ad[1] ? wd[31:16] : wd[15:0]);
            end
            if (ph >= 3'd2) begin
                if (!narrow)
                    bus_din = rd;
                else if (ph == 3'd3)
                    bus_din = {16'hDEAD, rd[15:0]};
                else if (ph == 3'd4)
                    bus_din = {16'hDEAD, rd[31:16]};
                else
                    bus_din = {16'hDEAD, ad[1] ? rd[31:16] : rd[15:0]};
                bus_ready = (k == waits);
                k++;
            end else begin
                bus_ready = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        bus_ready = 1'b0;
        check("R11 done seen", seen, 1'b1);
        check("R10 busy cycles", cyc, 1 + (word16 ? 2 : 1) * (waits + 1));
        check(word16 ? "R6 state order" : "R3 R5 state order", seq, word16 ? 92 : 10);
        if (!wr) begin
            if (!narrow || sz[1]) exp_rd = rd;
            else exp_rd = ad[1] ? {rd[31:16], 16'h0} : {16'h0, rd[15:0]};
            check(word16 ? "R7 word read packing" : (narrow ? "R9 read steering" : "R3 wide read"),
                  rword, exp_rd);
        end
        @(negedge clk);
        check("R11 done single pulse", rsp_done, 1'b0);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        @(negedge clk);
        check("R1 idle phase", bus_phase, 3'd0);
        check("R1 no enables", {bus_be, bus_doe}, 6'd0);
        check("R1 done low", rsp_done, 1'b0);
        check("R1 rdata zero", rsp_rdata, 32'd0);
        check("R1 ready high", req_ready, 1'b1);
    endtask

    task automatic t_wide;
        int s; logic [31:0] r;
        access(1'b0, 2'd0, 32'h1000_0002, 32'h0, 32'hA1B2C3D4, 0, s, r);
        access(1'b1, 2'd1, 32'h1000_0006, 32'h5566_7788, 32'h0, 1, s, r);
        access(1'b0, 2'd2, 32'h2000_0000, 32'h0, 32'hCAFE_F00D, 2, s, r);
        access(1'b1, 2'd2, 32'h2000_0004, 32'h0123_4567, 32'h0, 0, s, r);
        check("R3 word address", bus_addr, 30'h0800_0001);
    endtask

    task automatic t_strap_ignored_wide;
        int s; logic [31:0] r;
        strap_narrow = 1'b1;
        access(1'b0, 2'd2, 32'h30, 32'h0, 32'h1357_9BDF, 0, s, r);
        check("R2 strap change ignored wide", s, 10);
    endtask

    task automatic t_narrow_word_read;
        int s; logic [31:0] r;
        do_reset(1'b1);
        strap_narrow = 1'b0;
        access(1'b0, 2'd2, 32'h40, 32'h0, 32'h89AB_CDEF, 0, s, r);
        check("R2 strap change ignored narrow", s, 92);
        access(1'b0, 2'd2, 32'h44, 32'h0, 32'h0F1E_2D3C, 3, s, r);
        check("R4 upper lanes ignored", r, 32'h0F1E_2D3C);
    endtask

    task automatic t_narrow_word_write;
        int s; logic [31:0] r;
        access(1'b1, 2'd2, 32'h48, 32'hBEEF_1234, 32'h0, 1, s, r);
    endtask

    task automatic t_halfwords;
        int s; logic [31:0] r;
        access(1'b0, 2'd1, 32'h52, 32'h0, 32'hAAAA_5555, 0, s, r);
        access(1'b0, 2'd1, 32'h50, 32'h0, 32'hAAAA_5555, 0, s, r);
        access(1'b1, 2'd1, 32'h56, 32'h7654_3210, 32'h0, 0, s, r);
        access(1'b1, 2'd1, 32'h54, 32'h7654_3210, 32'h0, 2, s, r);
    endtask

    task automatic t_bytes;
        int s; logic [31:0] r;
        access(1'b0, 2'd0, 32'h63, 32'h0, 32'h1122_3344, 0, s, r);
        access(1'b1, 2'd0, 32'h61, 32'h0000_9900, 32'h0, 0, s, r);
        access(1'b0, 2'd0, 32'h60, 32'h0, 32'h1122_3344, 4, s, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_wide();
        t_strap_ignored_wide();
        t_narrow_word_read();
        t_narrow_word_write();
        t_halfwords();
        t_bytes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule